// File: doc/BRIEF.md
# Packet Test Pattern Verifier

This block sits on a 32-bit receive path that carries four control flags per word and runs at 156.25 MHz. It checks test packets sent by a remote pattern source. For each packet it rebuilds the expected payload locally and compares it with the received payload. Every payload word that differs adds one to an error counter.

The block has two pattern modes. In the random mode the expected payload comes from a 32-bit LFSR. In the jitter mode the expected payload is a fixed, repeating run of high-transition words followed by low-transition words. Each mode has its own pattern-enable bit and its own check-enable bit. A shared test-enable bit must also be set before any checking happens. If both modes are enabled at once, the block flags the conflict and does no checking.

Checking starts only after the block has seen a start word followed by a start-of-frame word. A sticky sync flag shows software that this has happened. Software reads the error counter through a small register port, and each read clears the counter. A soft-reset bit returns the block to its unsynchronised state before a new test.

Top module: `pkt_pattern_checker`

## Requirements
- R1: No payload word is compared until the block has seen a start word followed directly by a start-of-frame word. A start word has rxCtrl=4'b0001 and rxData=32'h555555FB. A start-of-frame word has rxCtrl=4'b0000 and rxData=32'hD5555555. Comparison begins on the word after the start-of-frame word.
- R2: Status register (address 1) bit 0 is the sync flag. It is 0 until a start/start-of-frame pair has been accepted. After that it stays 1 until a hard or soft reset.
- R3: The error counter is read at address 2. A read returns the current count and clears the counter. If a mismatch arrives in the same cycle as a read, the counter holds 1 after that cycle.
- R4: The error counter is 16 bits wide. It increments once per mismatched payload word and stays at 16'hFFFF instead of wrapping.
- R5: Random mode is active when control bits 0 (pattern enable) and 2 (check enable) are both set, together with test enable (bit 4). In this mode the expected word starts at 32'hFFFFFFFF at each start-of-frame word. After each payload word it steps as a Galois LFSR: shift left by one, then XOR with 32'h00400007 if the old bit 31 was 1.
- R6: Jitter mode is active when control bits 1 and 3 are both set, together with bit 4. The expected sequence restarts at each start-of-frame word and has a period of 8. Positions 0 to 3 expect 32'hAAAAAAAA and positions 4 to 7 expect 32'hFFFF0000.
- R7: If both modes are active at once, status bit 1 reads 1. While the conflict lasts, no sync is acquired and no errors are counted.
- R8: When test enable (bit 4) is 0, or when a mode has only one of its two bits set, no errors are counted. Clearing test enable does not clear the sync flag.
- R9: Any word with a control flag set ends a packet and is not compared. Data words that arrive outside a packet are ignored. The expected sequence realigns at the next start-of-frame word.
- R10: Writing address 0 with bit 5 set is a soft reset. It clears the control bits, the sync flag, the error counter and the framing state, and bit 5 always reads back 0.
- R11: After hard reset, the control register (address 0), status register (address 1) and error counter (address 2) all read 0. Address 3 always reads 0. Writes to any address other than 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 156.25 MHz data and register clock |
| rstN | input | 1 | Active-low hard reset, synchronous |
| rxData | input | 32 | Received data word, lane 0 in bits 7:0 |
| rxCtrl | input | 4 | Control flag per lane, bit 0 for lane 0 |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe, clears the counter when address is 2 |
| regAddr | input | 2 | Register address |
| regWrData | input | 6 | Write data for the control register |
| regRdData | output | 16 | Read data for regAddr, combinational |

## Verification
A framing state that goes wrong shows up at the ports in one of three ways. The sync flag rises without a valid start/start-of-frame pair. The sync flag never rises. Or the error count grows on packets that are actually clean. A misaligned LFSR or jitter index corrupts almost every word of the next packet, so the count read right after that packet shows the fault at once. A counter that wraps, or that loses the increment landing on a read cycle, shows up on the very next read of address 2.

// File: rtl/pkt_chk_pkg.sv
package pkt_chk_pkg;

  localparam int DATA_W = 32;
  localparam int CTRL_W = 4;

  localparam logic [DATA_W-1:0] START_WORD = 32'h5555_55FB;
  localparam logic [CTRL_W-1:0] START_CTRL = 4'b0001;
  localparam logic [DATA_W-1:0] SFD_WORD   = 32'hD555_5555;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_ERRCNT = 2'd2;

  localparam int BIT_RND_PAT = 0;
  localparam int BIT_JIT_PAT = 1;
  localparam int BIT_RND_CHK = 2;
  localparam int BIT_JIT_CHK = 3;
  localparam int BIT_TEST_EN = 4;
  localparam int BIT_SOFT_RST = 5;

  typedef enum logic [1:0] {
    FR_IDLE    = 2'd0,
    FR_STARTED = 2'd1,
    FR_PAYLOAD = 2'd2
  } frameStateT;

  typedef struct packed {
    logic reseed;
    logic compare;
    logic useJitter;
    logic cntClear;
    logic hardClear;
  } chkStrobeT;

endpackage

// File: rtl/pkt_chk_ctrl.sv
module pkt_chk_ctrl
  import pkt_chk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rxData,
  input  logic [CTRL_W-1:0] rxCtrl,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [WR_W-1:0]   regWrData,
  input  logic [CNT_W-1:0]  errCount,
  output logic [CNT_W-1:0]  regRdData,
  output chkStrobeT         strobes,
  output logic              syncSeen,
  output logic              conflict
);

  localparam int CFG_W = WR_W - 1;

  logic [CFG_W-1:0] cfgReg;
  frameStateT       state, stateNext;
  logic             softRst;
  logic             rndActive, jitActive, checkOn;
  logic             isStart, isSfd, anyCtrl;

  assign softRst   = regWrEn && (regAddr == ADDR_CTRL) && regWrData[BIT_SOFT_RST];
  assign rndActive = cfgReg[BIT_RND_PAT] && cfgReg[BIT_RND_CHK];
  assign jitActive = cfgReg[BIT_JIT_PAT] && cfgReg[BIT_JIT_CHK];
  assign conflict  = rndActive && jitActive;
  assign checkOn   = cfgReg[BIT_TEST_EN] && (rndActive ^ jitActive);

  assign isStart = (rxCtrl == START_CTRL) && (rxData == START_WORD);
  assign isSfd   = (rxCtrl == '0) && (rxData == SFD_WORD);
  assign anyCtrl = |rxCtrl;

  always_comb begin
    stateNext = state;
    unique case (state)
      FR_IDLE:    if (isStart) stateNext = FR_STARTED;
      FR_STARTED: begin
        if (isSfd)        stateNext = FR_PAYLOAD;
        else if (isStart) stateNext = FR_STARTED;
        else              stateNext = FR_IDLE;
      end
      FR_PAYLOAD: begin
        if (isStart)      stateNext = FR_STARTED;
        else if (anyCtrl) stateNext = FR_IDLE;
      end
      default:            stateNext = FR_IDLE;
    endcase
    if (!checkOn) stateNext = FR_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      state    <= FR_IDLE;
      syncSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (checkOn && state == FR_STARTED && isSfd) syncSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      cfgReg <= '0;
    end else if (regWrEn && regAddr == ADDR_CTRL) begin
      cfgReg <= regWrData[CFG_W-1:0];
    end
  end

  always_comb begin
    strobes.reseed    = checkOn && (state == FR_STARTED) && isSfd;
    strobes.compare   = checkOn && (state == FR_PAYLOAD) && !anyCtrl;
    strobes.useJitter = jitActive;
    strobes.cntClear  = regRdEn && (regAddr == ADDR_ERRCNT);
    strobes.hardClear = softRst;
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTRL:   regRdData[CFG_W-1:0] = cfgReg;
      ADDR_STATUS: regRdData[1:0]       = {conflict, syncSeen};
      ADDR_ERRCNT: regRdData            = errCount;
      default:     regRdData            = '0;
    endcase
  end

endmodule

// File: rtl/pkt_chk_datapath.sv
module pkt_chk_datapath
  import pkt_chk_pkg::*;
#(
  parameter int              CNT_W      = 16,
  parameter int              JIT_PERIOD = 8,
  parameter logic [DATA_W-1:0] LFSR_SEED = 32'hFFFF_FFFF,
  parameter logic [DATA_W-1:0] LFSR_TAPS = 32'h0040_0007,
  parameter logic [DATA_W-1:0] JIT_HIGH  = 32'hAAAA_AAAA,
  parameter logic [DATA_W-1:0] JIT_LOW   = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rxData,
  input  chkStrobeT         strobes,
  output logic [CNT_W-1:0]  errCount
);

  localparam int IDX_W = (JIT_PERIOD > 1) ? $clog2(JIT_PERIOD) : 1;
  localparam int HALF  = JIT_PERIOD / 2;

  logic [DATA_W-1:0] lfsr;
  logic [IDX_W-1:0]  jitIdx;
  logic [DATA_W-1:0] jitTable [JIT_PERIOD];
  logic [DATA_W-1:0] expected;
  logic              mismatch;

  for (genvar i = 0; i < JIT_PERIOD; i++) begin : g_jitTable
    if (i < HALF) begin : g_high
      assign jitTable[i] = JIT_HIGH;
    end else begin : g_low
      assign jitTable[i] = JIT_LOW;
    end
  end

  function automatic logic [DATA_W-1:0] lfsrStep(input logic [DATA_W-1:0] cur);
    return {cur[DATA_W-2:0], 1'b0} ^ (cur[DATA_W-1] ? LFSR_TAPS : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || strobes.hardClear || strobes.reseed) begin
      lfsr   <= LFSR_SEED;
      jitIdx <= '0;
    end else if (strobes.compare) begin
      lfsr   <= lfsrStep(lfsr);
      jitIdx <= (jitIdx == IDX_W'(JIT_PERIOD - 1)) ? '0 : jitIdx + 1'b1;
    end
  end

  assign expected = strobes.useJitter ? jitTable[jitIdx] : lfsr;
  assign mismatch = strobes.compare && (rxData != expected);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.hardClear) begin
      errCount <= '0;
    end else if (strobes.cntClear) begin
      errCount <= mismatch ? CNT_W'(1) : '0;
    end else if (mismatch && errCount != '1) begin
      errCount <= errCount + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_pattern_checker.sv
module pkt_pattern_checker
  import pkt_chk_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int WR_W       = 6,
  parameter int JIT_PERIOD = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       rxData,
  input  logic [3:0]        rxCtrl,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [WR_W-1:0]   regWrData,
  output logic [CNT_W-1:0]  regRdData
);

  chkStrobeT        strobes;
  logic [CNT_W-1:0] errCount;
  logic             syncSeen;
  logic             conflict;

  pkt_chk_ctrl #(.CNT_W(CNT_W), .WR_W(WR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxData    (rxData),
    .rxCtrl    (rxCtrl),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .errCount  (errCount),
    .regRdData (regRdData),
    .strobes   (strobes),
    .syncSeen  (syncSeen),
    .conflict  (conflict)
  );

  pkt_chk_datapath #(.CNT_W(CNT_W), .JIT_PERIOD(JIT_PERIOD)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxData   (rxData),
    .strobes  (strobes),
    .errCount (errCount)
  );

endmodule

// File: rtl/pkt_chk_checks.sv
module pkt_chk_checks
  import pkt_chk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] errCount,
  input logic             syncSeen,
  input logic             conflict,
  input chkStrobeT        strobes
);

  assert_count_needs_sync_R1: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != '0) |-> syncSeen);

  assert_sync_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (syncSeen && !strobes.hardClear) |=> syncSeen);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntClear && !strobes.hardClear) |=> (errCount <= CNT_W'(1)));

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.cntClear && !strobes.hardClear) |=>
      (errCount == $past(errCount) || errCount == $past(errCount) + 1'b1));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == '1 && !strobes.cntClear && !strobes.hardClear) |=> (errCount == '1));

  assert_conflict_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    conflict |-> (!strobes.compare && !strobes.reseed));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hardClear |=> (!syncSeen && errCount == '0));

endmodule

bind pkt_pattern_checker pkt_chk_checks #(.CNT_W(CNT_W)) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .errCount (errCount),
  .syncSeen (syncSeen),
  .conflict (conflict),
  .strobes  (strobes)
);

// File: tb/pkt_pattern_checker_test.sv
module pkt_pattern_checker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] rxData = 32'h0707_0707;
  logic [3:0]  rxCtrl = 4'hF;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [5:0]  regWrData = 6'd0;
  logic [15:0] regRdData;

  int checks = 0;
  int failures = 0;
  int expCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pkt_pattern_checker uut (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxCtrl(rxCtrl),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [31:0] lfsrNext(input logic [31:0] v);
    return {v[30:0], 1'b0} ^ (v[31] ? 32'h0040_0007 : 32'h0);
  endfunction

  function automatic logic [31:0] jitWord(input int idx);
    return ((idx % 8) < 4) ? 32'hAAAA_AAAA : 32'hFFFF_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [31:0] d);
    @(negedge clk);
    rxCtrl = c;
    rxData = d;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(4'hF, 32'h0707_0707);
  endtask

  task automatic garbage(input int n);
    for (int i = 0; i < n; i++) drive(4'h0, $urandom);
  endtask

  task automatic sendPacket(input int len, input bit jit, input int errPct, input bit counts);
    logic [31:0] lf = 32'hFFFF_FFFF;
    drive(4'b0001, 32'h5555_55FB);
    drive(4'b0000, 32'hD555_5555);
    for (int i = 0; i < len; i++) begin
      logic [31:0] w = jit ? jitWord(i) : lf;
      if (int'($urandom % 100) < errPct) begin
        w = w ^ (32'h1 << ($urandom % 32));
        if (counts && expCount < 65535) expCount++;
      end
      drive(4'b0000, w);
      lf = lfsrNext(lf);
    end
    drive(4'hF, 32'h0707_07FD);
    idle(1);
  endtask

  task automatic readCount(input string req);
    logic [15:0] v;
    regRead(2'd2, v);
    check(req, {16'h0, v}, expCount);
    expCount = 0;
  endtask

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    regRead(2'd0, v); check("R11 ctrl reset", {16'h0, v}, 32'h0);
    regRead(2'd1, v); check("R11 status reset", {16'h0, v}, 32'h0);
    regRead(2'd2, v); check("R11 count reset", {16'h0, v}, 32'h0);
    regWrite(2'd3, 6'h1F);
    regRead(2'd3, v); check("R11 addr3 reads zero", {16'h0, v}, 32'h0);

    regWrite(2'd0, 6'h15);
    garbage(20);
    regRead(2'd1, v); check("R2 no sync before SFD", {16'h0, v}, 32'h0);
    readCount("R1 garbage before sync");
    drive(4'b0001, 32'h5555_55FB);
    drive(4'b0000, 32'h5555_5555);
    garbage(10);
    regRead(2'd1, v); check("R1 start without SFD", {16'h0, v}, 32'h0);
    readCount("R1 no compare without SFD");

    sendPacket(30, 1'b0, 0, 1'b1);
    regRead(2'd1, v); check("R2 sync after SFD", {16'h0, v}, 32'h1);
    readCount("R5 clean random packet");

    for (int p = 0; p < 12; p++) begin
      sendPacket(5 + int'($urandom % 40), 1'b0, int'($urandom % 50), 1'b1);
      garbage(int'($urandom % 4));
      idle(1);
      if (p % 3 == 2) readCount("R5 random packets");
    end
    readCount("R5 random tail");
    regRead(2'd2, v); check("R3 second read zero", {16'h0, v}, 32'h0);

    regWrite(2'd0, 6'h1A);
    regRead(2'd0, v); check("R11 ctrl readback", {16'h0, v}, 32'h1A);
    for (int p = 0; p < 10; p++) begin
      sendPacket(3 + int'($urandom % 20), 1'b1, int'($urandom % 40), 1'b1);
      garbage(2);
      readCount("R6 jitter packets");
    end
    sendPacket(8, 1'b0, 0, 1'b0);
    expCount = 8;
    begin
      logic [31:0] lf = 32'hFFFF_FFFF;
      int mm = 0;
      for (int i = 0; i < 8; i++) begin
        if (lf != jitWord(i)) mm++;
        lf = lfsrNext(lf);
      end
      expCount = mm;
    end
    readCount("R6 random words in jitter mode");

    regWrite(2'd0, 6'h1F);
    regRead(2'd1, v); check("R7 conflict flag", {16'h0, v}, 32'h3);
    sendPacket(20, 1'b0, 100, 1'b0);
    readCount("R7 no count on conflict");

    regWrite(2'd0, 6'h11);
    sendPacket(20, 1'b0, 100, 1'b0);
    readCount("R8 check enable missing");
    regWrite(2'd0, 6'h05);
    sendPacket(20, 1'b0, 100, 1'b0);
    readCount("R8 test enable cleared");
    regRead(2'd1, v); check("R8 sync kept", {16'h0, v}, 32'h1);

    regWrite(2'd0, 6'h15);
    sendPacket(10, 1'b0, 100, 1'b1);
    garbage(15);
    readCount("R9 outside words ignored");
    sendPacket(10, 1'b0, 0, 1'b1);
    readCount("R9 realign at SFD");

    sendPacket(3, 1'b0, 100, 1'b1);
    drive(4'b0001, 32'h5555_55FB);
    drive(4'b0000, 32'hD555_5555);
    @(negedge clk);
    rxCtrl = 4'b0000; rxData = 32'h0000_0001;
    regRdEn = 1'b1; regAddr = 2'd2;
    #1 v = regRdData;
    check("R3 read value before clear", {16'h0, v}, 32'd3);
    @(negedge clk);
    regRdEn = 1'b0;
    rxCtrl = 4'hF; rxData = 32'h0707_07FD;
    idle(1);
    expCount = 1;
    readCount("R3 mismatch on read cycle kept");

    sendPacket(65600, 1'b0, 100, 1'b1);
    readCount("R4 saturate");

    sendPacket(4, 1'b0, 100, 1'b1);
    regWrite(2'd0, 6'h35);
    regRead(2'd0, v); check("R10 ctrl cleared", {16'h0, v}, 32'h0);
    regRead(2'd1, v); check("R10 sync cleared", {16'h0, v}, 32'h0);
    expCount = 0;
    readCount("R10 count cleared");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule